// File: doc/BRIEF.md
# Raster Scan Memory Fetch Sequencer

This block produces the memory fetch sequence of a character or bitmap video scanner. It emits one fetch address per clock. Each scan line takes 65 clocks and reads 64 distinct bytes. The first 25 clocks of a line are horizontal blanking: 24 bytes are read there, and the first of them is read twice. The last 40 clocks are the visible region, which reads 40 contiguous bytes. Alongside the address, the block reports whether the current fetch is a visible one and which group of eight fetched bytes (octet) it belongs to.

The address map is a simplified linear one. The frame has 64 line slots of 128 bytes each in an 8 KiB page at 0x2000, and the slot is selected by the low six bits of the line number. Within a slot, the 64 bytes of a line run from offset 0x38 to 0x77. The blanking bytes come first, so the visible fetches start at offset 0x50.

The memory returns the byte for the current address during the same cycle. The block captures that byte at every clock edge. An unmapped I/O read therefore sees the byte the scanner fetched in the previous cycle. This models a floating data bus.

Top module: `raster_fetch_seq`

## Requirements
- R1: The horizontal position `hpos` counts 0 to 64 and then returns to 0, so a line lasts exactly 65 clocks.
- R2: The line number `vpos` advances by one only when `hpos` wraps from 64 to 0. It counts 0 to 261 and then returns to 0.
- R3: While `rst` is high at a clock edge, `hpos`, `vpos` and the captured bus byte are all cleared to zero.
- R4: For `hpos` from 1 to 24, `fetch_addr` is line base + 0x38 + (`hpos` - 1). At `hpos` 0 the address equals the one used at `hpos` 1.
- R5: For `hpos` from 25 to 64, `fetch_addr` is line base + 0x50 + (`hpos` - 25). The line base is 0x2000 + (`vpos` mod 64) × 0x80, so line 128 starts its visible fetches at 0x2050.
- R6: Within each line, the 65 fetches use exactly 64 distinct addresses. Their low six bits take every value 0 to 63 once, so a 64-row array is fully refreshed on every line.
- R7: `visible` is 1 exactly when `hpos` ≥ 25 and `vpos` < 192. It is 0 for all of lines 192 to 261.
- R8: `octet` is 0 at `hpos` 0 and is (`hpos` - 1) / 8 for `hpos` 1 to 64. This gives 0 to 2 during blanking and 3 to 7 in the visible region.
- R9: While `io_rd` is 1, `io_rdata` equals the value `mem_rdata` held during the previous clock. While `io_rd` is 0, `io_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 8 | Byte returned by memory for the current `fetch_addr` |
| io_rd | input | 1 | Unmapped I/O read in progress |
| fetch_addr | output | 16 | Byte address fetched this cycle |
| visible | output | 1 | Current fetch belongs to the visible part of an active line |
| octet | output | 3 | Index of the 8-byte group of the current fetch |
| hpos | output | 7 | Horizontal cycle position within the line |
| vpos | output | 9 | Line number within the frame |
| io_rdata | output | 8 | Floating-bus byte returned on unmapped reads |

## Verification
The full address, octet and visible sequence is checked on every clock of several chosen lines:
- Line 0 is the first active line, with slot 0.
- Line 128 reuses slot 0 and must start its visible fetches at 0x2050.
- Line 191 is the last active line.
- Line 192 is the first blanked line, where the visible flag must stay low.
- Line 261 is the last line, after which the counters must return to line 0.

The per-line set of low address bits shows whether any fetch is lost or duplicated. Whether the repeated fetch sits at cycle 0 separates a correct stream from one that is shifted by a clock. The memory model returns a byte that depends on the address, so the floating-bus check can tell a one-cycle-old byte from the current byte or a stale one. A reset in the middle of a line shows that the counters clear at once.

// File: rtl/raster_pkg.sv
package raster_pkg;

    parameter int LINE_CYCLES   = 65;
    parameter int BLANK_CYCLES  = 25;
    parameter int FRAME_LINES   = 262;
    parameter int ACTIVE_LINES  = 192;
    parameter int OCTET_LOG2    = 3;
    parameter int SLOT_BITS     = 6;   // 64 fetched bytes per line
    parameter int LINE_SEL_BITS = 6;   // 64 line slots in the page
    parameter int STRIDE_LOG2   = 7;   // 128-byte line slots
    parameter int AW            = 16;
    parameter int DW            = 8;
    parameter int HW            = $clog2(LINE_CYCLES);
    parameter int VW            = $clog2(FRAME_LINES);
    parameter logic [AW-1:0] PAGE_BASE  = 16'h2000;
    parameter logic [AW-1:0] STREAM_OFS = 16'h0038;

    typedef struct packed {
        logic [VW-1:0] v;
        logic [HW-1:0] h;
    } scan_pos_t;

    typedef enum logic {
        PH_BLANK   = 1'b0,
        PH_VISIBLE = 1'b1
    } phase_e;

    // Index of the fetched byte within the line; cycle 0 repeats byte 0.
    function automatic logic [SLOT_BITS-1:0] byte_slot(input logic [HW-1:0] h);
        return (h == '0) ? '0 : SLOT_BITS'(h - HW'(1));
    endfunction

endpackage

// File: rtl/scan_counters.sv
module scan_counters
    import raster_pkg::*;
#(
    parameter int H_CYCLES = LINE_CYCLES,
    parameter int V_LINES  = FRAME_LINES
) (
    input  logic      clk,
    input  logic      rst,
    output scan_pos_t pos
);
    localparam logic [HW-1:0] H_LAST = HW'(H_CYCLES - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_LINES - 1);

    scan_pos_t pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (pos_q.h == H_LAST) begin
            pos_q.h <= '0;
            pos_q.v <= (pos_q.v == V_LAST) ? '0 : pos_q.v + VW'(1);
        end else begin
            pos_q.h <= pos_q.h + HW'(1);
        end
    end

    assign pos = pos_q;
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen
    import raster_pkg::*;
#(
    parameter int BLANK_LEN  = BLANK_CYCLES,
    parameter int ACTIVE_LEN = ACTIVE_LINES
) (
    input  scan_pos_t     pos,
    output logic [AW-1:0] fetch_addr,
    output logic [2:0]    octet,
    output logic          visible
);
    localparam logic [HW-1:0] VIS_START = HW'(BLANK_LEN);
    localparam logic [VW-1:0] ACT_END   = VW'(ACTIVE_LEN);

    logic [SLOT_BITS-1:0]     slot;
    logic [LINE_SEL_BITS-1:0] line_sel;
    logic [AW-1:0]            line_base;
    phase_e                   phase;

    always_comb begin
        slot       = byte_slot(pos.h);
        line_sel   = pos.v[LINE_SEL_BITS-1:0];
        line_base  = PAGE_BASE + (AW'(line_sel) << STRIDE_LOG2);
        fetch_addr = line_base + STREAM_OFS + AW'(slot);
        octet      = slot[SLOT_BITS-1 -: 3];
        phase      = (pos.h >= VIS_START) ? PH_VISIBLE : PH_BLANK;
        visible    = (phase == PH_VISIBLE) && (pos.v < ACT_END);
    end
endmodule

// File: rtl/float_bus_latch.sv
module float_bus_latch
    import raster_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] bus_in,
    input  logic          rd,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else     held_q <= bus_in;
    end

    assign rd_data = rd ? held_q : '0;
endmodule

// File: rtl/raster_fetch_seq.sv
module raster_fetch_seq
    import raster_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    mem_rdata,
    input  logic          io_rd,
    output logic [15:0]   fetch_addr,
    output logic          visible,
    output logic [2:0]    octet,
    output logic [6:0]    hpos,
    output logic [8:0]    vpos,
    output logic [7:0]    io_rdata
);
    scan_pos_t pos;

    scan_counters #(
        .H_CYCLES(LINE_CYCLES),
        .V_LINES (FRAME_LINES)
    ) u_cnt (
        .clk(clk),
        .rst(rst),
        .pos(pos)
    );

    fetch_addr_gen #(
        .BLANK_LEN (BLANK_CYCLES),
        .ACTIVE_LEN(ACTIVE_LINES)
    ) u_addr (
        .pos       (pos),
        .fetch_addr(fetch_addr),
        .octet     (octet),
        .visible   (visible)
    );

    float_bus_latch u_float (
        .clk    (clk),
        .rst    (rst),
        .bus_in (mem_rdata),
        .rd     (io_rd),
        .rd_data(io_rdata)
    );

    assign hpos = pos.h;
    assign vpos = pos.v;
endmodule

// File: rtl/raster_fetch_seq_chk.sv
module raster_fetch_seq_chk
    import raster_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [7:0]  mem_rdata,
    input logic        io_rd,
    input logic [15:0] fetch_addr,
    input logic        visible,
    input logic [2:0]  octet,
    input logic [6:0]  hpos,
    input logic [8:0]  vpos,
    input logic [7:0]  io_rdata
);
    localparam logic [6:0] H_LAST = 7'(LINE_CYCLES - 1);
    localparam logic [8:0] V_LAST = 9'(FRAME_LINES - 1);
    localparam logic [8:0] V_ACT  = 9'(ACTIVE_LINES);

    // R1
    h_range_chk: assert property (@(posedge clk) disable iff (rst) hpos <= H_LAST);
    // R1
    h_wrap_chk: assert property (@(posedge clk) disable iff (rst) hpos == H_LAST |=> hpos == 7'd0);
    // R1
    h_step_chk: assert property (@(posedge clk) disable iff (rst)
        hpos != H_LAST |=> hpos == $past(hpos) + 7'd1);
    // R2
    v_hold_chk: assert property (@(posedge clk) disable iff (rst) hpos != H_LAST |=> $stable(vpos));
    // R2
    v_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (hpos == H_LAST && vpos == V_LAST) |=> vpos == 9'd0);
    // R4
    repeat_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        hpos == 7'd0 |=> $stable(fetch_addr));
    // R7
    blank_line_chk: assert property (@(posedge clk) disable iff (rst) vpos >= V_ACT |-> !visible);
    // R8
    octet_blank_chk: assert property (@(posedge clk) disable iff (rst)
        hpos < 7'(BLANK_CYCLES) |-> octet <= 3'd2);
    // R9
    float_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !$past(rst)) |-> io_rdata == $past(mem_rdata));
endmodule

bind raster_fetch_seq raster_fetch_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .io_rd     (io_rd),
    .fetch_addr(fetch_addr),
    .visible   (visible),
    .octet     (octet),
    .hpos      (hpos),
    .vpos      (vpos),
    .io_rdata  (io_rdata)
);

// File: tb/raster_fetch_seq_tb.sv
`timescale 1ns/1ps
module raster_fetch_seq_tb;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_rd = 1'b1;
    logic [7:0]  mem_rdata;
    logic [15:0] fetch_addr;
    logic        visible;
    logic [2:0]  octet;
    logic [6:0]  hpos;
    logic [8:0]  vpos;
    logic [7:0]  io_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    // memory model: byte depends on the whole address
    assign mem_rdata = fetch_addr[7:0] ^ {fetch_addr[14:8], 1'b0} ^ 8'h5A;

    raster_fetch_seq u_dut (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .io_rd(io_rd),
        .fetch_addr(fetch_addr), .visible(visible), .octet(octet),
        .hpos(hpos), .vpos(vpos), .io_rdata(io_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (v=%0d h=%0d)", req, act, exp, vpos, hpos);
        end
    endtask

    function automatic int exp_addr(input int v, input int h);
        int base = 'h2000 + (v % 64) * 'h80;
        if (h == 0)       return base + 'h38;
        else if (h <= 24) return base + 'h38 + h - 1;
        else              return base + 'h50 + h - 25;
    endfunction

    task automatic skip_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        io_rd = 1'b1;
        skip_cycles(3);
        rst = 1'b0;
        chk(hpos == 0, "R3 hpos", hpos, 0);
        chk(vpos == 0, "R3 vpos", vpos, 0);
        chk(io_rdata == 0, "R3 latch", io_rdata, 0);
    endtask

    // Checks every cycle of the line expected to start now (hpos == 0).
    task automatic t_line(input int v);
        bit [63:0] seen = '0;
        int a0 = 0;
        logic [7:0] prev = 8'h00;
        for (int k = 0; k < 65; k++) begin
            chk(hpos == 7'(k), "R1 hpos", hpos, k);
            chk(vpos == 9'(v), "R2 vpos", vpos, v);
            chk(int'(fetch_addr) == exp_addr(v, k), (k < 25) ? "R4 addr" : "R5 addr",
                fetch_addr, exp_addr(v, k));
            chk(int'(octet) == ((k == 0) ? 0 : (k - 1) / 8), "R8 octet", octet,
                (k == 0) ? 0 : (k - 1) / 8);
            chk(visible == ((k >= 25) && (v < 192)), "R7 visible", visible,
                int'((k >= 25) && (v < 192)));
            if (k == 0) a0 = fetch_addr;
            if (k == 1) chk(int'(fetch_addr) == a0, "R4 repeat", fetch_addr, a0);
            if (k > 0)  chk(io_rdata == prev, "R9 float", io_rdata, prev);
            seen[fetch_addr[5:0]] = 1'b1;
            prev = mem_rdata;
            @(negedge clk);
        end
        chk($countones(seen) == 64, "R6 coverage", $countones(seen), 64);
    endtask

    task automatic t_line128_start();
        skip_cycles(25);
        chk(fetch_addr == 16'h2050, "R5 line128 start", fetch_addr, 'h2050);
        chk(visible == 1'b1, "R7 line128 visible", visible, 1);
        skip_cycles(40);
    endtask

    task automatic t_frame_wrap();
        chk(vpos == 0 && hpos == 0, "R2 frame wrap", {vpos, hpos}, 0);
    endtask

    task automatic t_io_idle();
        io_rd = 1'b0;
        skip_cycles(1);
        chk(io_rdata == 0, "R9 idle", io_rdata, 0);
        skip_cycles(1);
        chk(io_rdata == 0, "R9 idle", io_rdata, 0);
        io_rd = 1'b1;
    endtask

    task automatic t_mid_reset();
        skip_cycles(100);
        rst = 1'b1;
        skip_cycles(1);
        rst = 1'b0;
        chk(hpos == 0, "R3 mid hpos", hpos, 0);
        chk(vpos == 0, "R3 mid vpos", vpos, 0);
        chk(io_rdata == 0, "R3 mid latch", io_rdata, 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_line(0);
        skip_cycles(127 * 65);
        t_line(128);
        skip_cycles(62 * 65);
        t_line(191);
        t_line(192);
        skip_cycles(68 * 65);
        t_line(261);
        t_frame_wrap();
        skip_cycles(128 * 65);
        t_line128_start();
        t_io_idle();
        t_mid_reset();
        t_line(0);
        finish_run();
    end

    initial begin
        #(CLK_P * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule